// File: doc/BRIEF.md
# Multi-Width Aliased Floating-Point Register File

This block holds the floating-point operand storage of a processor core. One pool of 64-bit registers can be read and written at three widths: 32-bit single, 64-bit double and 128-bit quad. The narrower views overlay the wider ones. A single is one half of a double, and a quad is an aligned pair of doubles. Two combinational read ports and one clocked write port each carry a 2-bit width code and a 5-bit register number. Read data is always 128 bits wide. The lanes above the operand width are driven to zero.

Storage is split into a base bank of 16 doubles and an extension bank of 16 further doubles. The extension bank can be used only while the extension mode bit is set, and only at double or quad width. When the mode is set, bit 0 of a double or quad register number chooses the extension bank, so register numbers stay 5 bits wide. A request that cannot be encoded raises an illegal flag on its port. An illegal read returns zero, and an illegal write is discarded.

Top module: `fprf_top`

## Requirements
- R1: When `rst` is high at a clock edge, every stored bit is cleared and `ext_mode` is cleared. After reset, every legal read returns zero.
- R2: Width code 2'b00 selects a single. Single n is bits [63:32] of base double n/2 when n is even, and bits [31:0] when n is odd. A single read returns the value in `r*_data[31:0]`, and bits [127:32] are zero.
- R3: A single write changes only its own 32-bit half. The other half of that double is unchanged.
- R4: Width code 2'b01 selects a double. With bit 0 of the number clear, it addresses base double n[4:1]. A double read returns the value in `r*_data[63:0]`, and bits [127:64] are zero. A double write takes effect at the next clock edge.
- R5: Width code 2'b10 selects a quad. A quad number with n[1:0]=00 covers base doubles n[4:2]*2 (returned in bits [127:64]) and n[4:2]*2+1 (returned in bits [63:0]). A quad write updates both doubles at the same edge.
- R6: A quad number with n[1]=1 is illegal. The port's illegal flag is high, read data is zero, and a write is discarded.
- R7: When `mode_we` is high at a clock edge, `mode_wd` is loaded into `ext_mode`. A register access in that same cycle uses the old mode.
- R8: While `ext_mode` is 1, a double or quad number with bit 0 set addresses the extension bank. That bank uses the same index rules as R4 and R5, and its storage is separate from the base bank.
- R9: Singles always address the base bank, whatever the mode. While `ext_mode` is 0, a double or quad number with bit 0 set is illegal. Width code 2'b11 is always illegal. Illegal reads return zero, and illegal writes are discarded.
- R10: A read of a register being written in the same cycle returns the old contents. The two read ports work independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_we | input | 1 | Load enable for the extension mode bit |
| mode_wd | input | 1 | New extension mode value |
| ext_mode | output | 1 | Current extension mode |
| ra_prec | input | 2 | Read port A width code |
| ra_num | input | 5 | Read port A register number |
| ra_data | output | 128 | Read port A data, zero-extended |
| ra_ill | output | 1 | Read port A illegal request |
| rb_prec | input | 2 | Read port B width code |
| rb_num | input | 5 | Read port B register number |
| rb_data | output | 128 | Read port B data, zero-extended |
| rb_ill | output | 1 | Read port B illegal request |
| w_en | input | 1 | Write enable |
| w_prec | input | 2 | Write width code |
| w_num | input | 5 | Write register number |
| w_data | input | 128 | Write data: single in [31:0], double in [63:0], quad in [127:0] |
| w_ill | output | 1 | Write enabled but illegal, so it is discarded |

## Verification
The assertions check the following on every cycle:
- Zero-extension of single and double reads.
- Zero data on illegal reads.
- The illegal flag for misaligned quads and for extension-bank access with the mode off.
- Loading of the mode bit.
- Read-back of a double in the cycle after it is written.

Only the bench's reference model can show the aliasing between views. This covers:
- The half selection of singles.
- The preservation of the other half on a single write.
- Both doubles changing on a quad write.
- Separation of the two banks.
- Suppression of illegal writes, which the model sees when the untouched registers are read back later.

// File: rtl/fprf_pkg.sv
package fprf_pkg;
    parameter int SGL_W     = 32;
    parameter int NUM_W     = 5;
    parameter int BANK_DBL  = 16;
    parameter int NUM_RD    = 2;

    localparam int DBL_W    = 2 * SGL_W;
    localparam int QUAD_W   = 2 * DBL_W;
    localparam int NUM_DBL  = 2 * BANK_DBL;
    localparam int IDX_W    = $clog2(BANK_DBL);
    localparam int SLOT_W   = IDX_W + 1;

    typedef enum logic [1:0] {
        PREC_S   = 2'b00,
        PREC_D   = 2'b01,
        PREC_Q   = 2'b10,
        PREC_BAD = 2'b11
    } prec_e;

    typedef struct packed {
        logic             legal;
        prec_e            prec;
        logic             bank;
        logic [IDX_W-1:0] idx;
        logic             upper_half;
    } acc_s;

    function automatic acc_s decode_acc(input prec_e p, input logic [NUM_W-1:0] n,
                                        input logic ext);
        acc_s a;
        a            = '0;
        a.prec       = p;
        a.idx        = n[NUM_W-1:1];
        a.upper_half = ~n[0];
        unique case (p)
            PREC_S: begin
                a.bank  = 1'b0;
                a.legal = 1'b1;
            end
            PREC_D: begin
                a.bank  = n[0];
                a.legal = ~n[0] | ext;
            end
            PREC_Q: begin
                a.bank  = n[0];
                a.idx   = {n[NUM_W-1:2], 1'b0};
                a.legal = ~n[1] & (~n[0] | ext);
            end
            default: a.legal = 1'b0;
        endcase
        return a;
    endfunction

    function automatic logic [SLOT_W-1:0] slot_of(input logic bank, input logic [IDX_W-1:0] idx);
        return {bank, idx};
    endfunction
endpackage

// File: rtl/fprf_decode.sv
module fprf_decode
    import fprf_pkg::*;
(
    input  logic [1:0]       prec,
    input  logic [NUM_W-1:0] num,
    input  logic             ext,
    output acc_s             acc
);
    always_comb begin
        acc = decode_acc(prec_e'(prec), num, ext);
    end
endmodule

// File: rtl/fprf_mode.sv
module fprf_mode (
    input  logic clk,
    input  logic rst,
    input  logic we,
    input  logic wd,
    output logic ext
);
    always_ff @(posedge clk) begin
        if (rst)     ext <= 1'b0;
        else if (we) ext <= wd;
    end
endmodule

// File: rtl/fprf_store.sv
module fprf_store
    import fprf_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr_en,
    input  acc_s                            wacc,
    input  logic [QUAD_W-1:0]               wdata,
    output logic [NUM_DBL-1:0][DBL_W-1:0]   slots
);
    for (genvar g = 0; g < NUM_DBL; g++) begin : g_slot
        localparam logic             G_BANK = 1'((g / BANK_DBL) != 0);
        localparam logic [IDX_W-1:0] G_IDX  = IDX_W'(g % BANK_DBL);

        logic             go, bank_hit, dbl_hit, pair_hit;
        logic             we_hi, we_lo;
        logic [SGL_W-1:0] d_hi, d_lo;
        logic [SGL_W-1:0] r_hi, r_lo;

        always_comb begin
            go       = wr_en & wacc.legal;
            bank_hit = (wacc.bank == G_BANK);
            dbl_hit  = bank_hit & (wacc.idx == G_IDX);
            pair_hit = bank_hit & (wacc.idx[IDX_W-1:1] == G_IDX[IDX_W-1:1]);
            we_hi    = 1'b0;
            we_lo    = 1'b0;
            d_hi     = wdata[DBL_W-1:SGL_W];
            d_lo     = wdata[SGL_W-1:0];
            unique case (wacc.prec)
                PREC_S: begin
                    we_hi = go & dbl_hit & wacc.upper_half;
                    we_lo = go & dbl_hit & ~wacc.upper_half;
                    d_hi  = wdata[SGL_W-1:0];
                end
                PREC_D: begin
                    we_hi = go & dbl_hit;
                    we_lo = go & dbl_hit;
                end
                PREC_Q: begin
                    we_hi = go & pair_hit;
                    we_lo = go & pair_hit;
                    if (!G_IDX[0]) begin
                        d_hi = wdata[QUAD_W-1:QUAD_W-SGL_W];
                        d_lo = wdata[QUAD_W-SGL_W-1:DBL_W];
                    end
                end
                default: ;
            endcase
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                r_hi <= '0;
                r_lo <= '0;
            end else begin
                if (we_hi) r_hi <= d_hi;
                if (we_lo) r_lo <= d_lo;
            end
        end

        assign slots[g] = {r_hi, r_lo};
    end
endmodule

// File: rtl/fprf_rport.sv
module fprf_rport
    import fprf_pkg::*;
(
    input  logic [NUM_DBL-1:0][DBL_W-1:0] slots,
    input  acc_s                          acc,
    output logic [QUAD_W-1:0]             data,
    output logic                          ill
);
    logic [SLOT_W-1:0] s0, s1;
    logic [DBL_W-1:0]  d0, d1;

    always_comb begin
        s0   = slot_of(acc.bank, acc.idx);
        s1   = slot_of(acc.bank, {acc.idx[IDX_W-1:1], 1'b1});
        d0   = slots[s0];
        d1   = slots[s1];
        ill  = ~acc.legal;
        data = '0;
        if (acc.legal) begin
            unique case (acc.prec)
                PREC_S:  data = QUAD_W'(acc.upper_half ? d0[DBL_W-1:SGL_W] : d0[SGL_W-1:0]);
                PREC_D:  data = QUAD_W'(d0);
                PREC_Q:  data = {d0, d1};
                default: data = '0;
            endcase
        end
    end
endmodule

// File: rtl/fprf_top.sv
module fprf_top
    import fprf_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               mode_we,
    input  logic               mode_wd,
    output logic               ext_mode,
    input  logic [1:0]         ra_prec,
    input  logic [NUM_W-1:0]   ra_num,
    output logic [QUAD_W-1:0]  ra_data,
    output logic               ra_ill,
    input  logic [1:0]         rb_prec,
    input  logic [NUM_W-1:0]   rb_num,
    output logic [QUAD_W-1:0]  rb_data,
    output logic               rb_ill,
    input  logic               w_en,
    input  logic [1:0]         w_prec,
    input  logic [NUM_W-1:0]   w_num,
    input  logic [QUAD_W-1:0]  w_data,
    output logic               w_ill
);
    logic [NUM_DBL-1:0][DBL_W-1:0] slots;
    acc_s                          wacc;
    logic [NUM_RD-1:0][1:0]        rd_prec;
    logic [NUM_RD-1:0][NUM_W-1:0]  rd_num;
    logic [NUM_RD-1:0][QUAD_W-1:0] rd_data;
    logic [NUM_RD-1:0]             rd_ill;

    fprf_mode i_mode (
        .clk (clk),
        .rst (rst),
        .we  (mode_we),
        .wd  (mode_wd),
        .ext (ext_mode)
    );

    fprf_decode i_wdec (
        .prec (w_prec),
        .num  (w_num),
        .ext  (ext_mode),
        .acc  (wacc)
    );

    fprf_store i_store (
        .clk   (clk),
        .rst   (rst),
        .wr_en (w_en),
        .wacc  (wacc),
        .wdata (w_data),
        .slots (slots)
    );

    assign rd_prec = {rb_prec, ra_prec};
    assign rd_num  = {rb_num, ra_num};

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        acc_s racc;
        fprf_decode i_rdec (
            .prec (rd_prec[p]),
            .num  (rd_num[p]),
            .ext  (ext_mode),
            .acc  (racc)
        );
        fprf_rport i_rport (
            .slots (slots),
            .acc   (racc),
            .data  (rd_data[p]),
            .ill   (rd_ill[p])
        );
    end

    assign ra_data = rd_data[0];
    assign ra_ill  = rd_ill[0];
    assign rb_data = rd_data[1];
    assign rb_ill  = rd_ill[1];
    assign w_ill   = w_en & ~wacc.legal;
endmodule

// File: rtl/fprf_chk.sv
module fprf_chk
    import fprf_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               mode_we,
    input logic               mode_wd,
    input logic               ext_mode,
    input logic [1:0]         ra_prec,
    input logic [NUM_W-1:0]   ra_num,
    input logic [QUAD_W-1:0]  ra_data,
    input logic               ra_ill,
    input logic               w_en,
    input logic [1:0]         w_prec,
    input logic [NUM_W-1:0]   w_num,
    input logic [QUAD_W-1:0]  w_data,
    input logic               w_ill
);
    logic past_ok;
    logic past_rst;

    always_ff @(posedge clk) begin
        past_ok  <= ~rst;
        past_rst <= rst;
    end

    always_ff @(posedge clk) begin
        if (past_rst === 1'b1 && !rst)
            AST_RESET_CLEAR: assert (ext_mode == 1'b0 && ra_data == '0); // R1
    end

    AST_SGL_ZEXT: assert property (@(posedge clk) disable iff (rst)
        (ra_prec == 2'b00) |-> (ra_data[QUAD_W-1:SGL_W] == '0)); // R2

    AST_DBL_ZEXT: assert property (@(posedge clk) disable iff (rst)
        (ra_prec == 2'b01) |-> (ra_data[QUAD_W-1:DBL_W] == '0)); // R4

    AST_DBL_READBACK: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(w_en && !w_ill && w_prec == 2'b01) && ra_prec == 2'b01
         && ra_num == $past(w_num) && !ra_ill)
        |-> (ra_data[DBL_W-1:0] == $past(w_data[DBL_W-1:0]))); // R4

    AST_QUAD_MISALIGN: assert property (@(posedge clk) disable iff (rst)
        (ra_prec == 2'b10 && ra_num[1]) |-> ra_ill); // R6

    AST_ILL_ZERO: assert property (@(posedge clk) disable iff (rst)
        ra_ill |-> (ra_data == '0)); // R6

    AST_MODE_LOAD: assert property (@(posedge clk) disable iff (rst)
        mode_we |=> (ext_mode == $past(mode_wd))); // R7

    AST_UPPER_GATED: assert property (@(posedge clk) disable iff (rst)
        (!ext_mode && ra_prec != 2'b00 && ra_num[0]) |-> ra_ill); // R9

    AST_BAD_CODE: assert property (@(posedge clk) disable iff (rst)
        (w_en && w_prec == 2'b11) |-> w_ill); // R9
endmodule

bind fprf_top fprf_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .mode_we  (mode_we),
    .mode_wd  (mode_wd),
    .ext_mode (ext_mode),
    .ra_prec  (ra_prec),
    .ra_num   (ra_num),
    .ra_data  (ra_data),
    .ra_ill   (ra_ill),
    .w_en     (w_en),
    .w_prec   (w_prec),
    .w_num    (w_num),
    .w_data   (w_data),
    .w_ill    (w_ill)
);

// File: tb/test_fprf_top.sv
module test_fprf_top;
    logic         clk = 1'b0;
    logic         rst;
    logic         mode_we, mode_wd, ext_mode;
    logic [1:0]   ra_prec, rb_prec, w_prec;
    logic [4:0]   ra_num, rb_num, w_num;
    logic [127:0] ra_data, rb_data, w_data;
    logic         ra_ill, rb_ill, w_en, w_ill;

    int errors = 0;
    int checks = 0;

    logic [63:0] m [32];
    logic        m_ext;

    always #10 clk = ~clk;

    fprf_top i_fprf_top (.*);

    function automatic logic [128:0] mread(input logic [1:0] p, input logic [4:0] n);
        int b;
        logic [63:0] d;
        case (p)
            2'd0: begin
                d = m[int'(n >> 1)];
                return {1'b0, 96'b0, (n[0] ? d[31:0] : d[63:32])};
            end
            2'd1: begin
                if (n[0] && !m_ext) return {1'b1, 128'b0};
                b = (n[0] ? 16 : 0) + int'(n >> 1);
                return {1'b0, 64'b0, m[b]};
            end
            2'd2: begin
                if (n[1] || (n[0] && !m_ext)) return {1'b1, 128'b0};
                b = (n[0] ? 16 : 0) + 2 * int'(n >> 2);
                return {1'b0, m[b], m[b+1]};
            end
            default: return {1'b1, 128'b0};
        endcase
    endfunction

    function automatic logic mwrite_ill(input logic [1:0] p, input logic [4:0] n);
        return mread(p, n) >> 128;
    endfunction

    function automatic string autotag(input logic [1:0] p, input logic [4:0] n);
        if (p == 2'd3) return "R9";
        if (p == 2'd2 && n[1]) return "R6";
        if (p != 2'd0 && n[0]) return m_ext ? "R8" : "R9";
        if (p == 2'd0) return "R2";
        if (p == 2'd1) return "R4";
        return "R5";
    endfunction

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [128:0] act, input logic [128:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic mwe, input logic mwd,
                        input logic [1:0] ap, input logic [4:0] an,
                        input logic [1:0] bp, input logic [4:0] bn,
                        input logic we, input logic [1:0] wp, input logic [4:0] wn,
                        input logic [127:0] wd, input string tag);
        logic [128:0] ea, eb;
        logic         ewi;
        string        ta, tb;
        int           b;
        @(negedge clk);
        mode_we = mwe; mode_wd = mwd;
        ra_prec = ap; ra_num = an; rb_prec = bp; rb_num = bn;
        w_en = we; w_prec = wp; w_num = wn; w_data = wd;
        #5;
        ea  = mread(ap, an);
        eb  = mread(bp, bn);
        ewi = we & mwrite_ill(wp, wn);
        ta  = (tag != "") ? tag : autotag(ap, an);
        tb  = (tag != "") ? tag : autotag(bp, bn);
        chk({ra_ill, ra_data} === ea, ta, "port A", {ra_ill, ra_data}, ea);
        chk({rb_ill, rb_data} === eb, tb, "port B", {rb_ill, rb_data}, eb);
        chk(w_ill === ewi, "R6", "write illegal flag", 129'(w_ill), 129'(ewi));
        chk(ext_mode === m_ext, "R7", "mode bit", 129'(ext_mode), 129'(m_ext));
        // model update for the coming edge (old mode governs this cycle's write)
        if (we && !ewi) begin
            case (wp)
                2'd0: if (wn[0]) m[int'(wn >> 1)][31:0] = wd[31:0];
                      else       m[int'(wn >> 1)][63:32] = wd[31:0];
                2'd1: m[(wn[0] ? 16 : 0) + int'(wn >> 1)] = wd[63:0];
                2'd2: begin
                    b = (wn[0] ? 16 : 0) + 2 * int'(wn >> 2);
                    m[b]   = wd[127:64];
                    m[b+1] = wd[63:0];
                end
                default: ;
            endcase
        end
        if (mwe) m_ext = mwd;
    endtask

    task automatic rd(input logic [1:0] ap, input logic [4:0] an,
                      input logic [1:0] bp, input logic [4:0] bn, input string tag);
        step(0, 0, ap, an, bp, bn, 0, 0, 0, '0, tag);
    endtask

    task automatic wr(input logic [1:0] wp, input logic [4:0] wn, input logic [127:0] wd,
                      input string tag);
        step(0, 0, 0, 0, 1, 0, 1, wp, wn, wd, tag);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) m[i] = '0;
        m_ext = 1'b0;
        rst = 1'b1;
        mode_we = 0; mode_wd = 0; ra_prec = 0; ra_num = 0; rb_prec = 0; rb_num = 0;
        w_en = 0; w_prec = 0; w_num = 0; w_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: everything reads zero after reset
        for (int n = 0; n < 32; n++) rd(2'd0, 5'(n), 2'd1, 5'(n & 30), "R1");
        rd(2'd2, 5'd0, 2'd2, 5'd28, "R1");

        // R4 / R2: fill doubles, read back as singles
        for (int k = 0; k < 16; k++)
            wr(2'd1, 5'(2 * k), {64'hdead, 32'hA000_0000 | 32'(k), 32'hB000_0000 | 32'(k)}, "R4");
        for (int n = 0; n < 32; n++) rd(2'd0, 5'(n), 2'd1, 5'(n & 30), "R2");

        // R3: single write touches only its half
        wr(2'd0, 5'd6, 128'h1111_2222, "R3");
        rd(2'd1, 5'd6, 2'd0, 5'd7, "R3");
        wr(2'd0, 5'd9, 128'h3333_4444, "R3");
        rd(2'd1, 5'd8, 2'd0, 5'd8, "R3");

        // R5: quad write and read
        wr(2'd2, 5'd12, {64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210}, "R5");
        rd(2'd1, 5'd12, 2'd1, 5'd14, "R5");
        rd(2'd2, 5'd12, 2'd0, 5'd13, "R5");

        // R6: misaligned quad is illegal and its write is dropped
        wr(2'd2, 5'd2, {128{1'b1}}, "R6");
        rd(2'd1, 5'd0, 2'd1, 5'd2, "R6");
        rd(2'd2, 5'd2, 2'd2, 5'd0, "R6");

        // R9: extension bank unreachable with mode off; code 3 illegal
        wr(2'd1, 5'd1, 128'h5555, "R9");
        rd(2'd1, 5'd1, 2'd1, 5'd0, "R9");
        wr(2'd3, 5'd4, 128'h7777, "R9");
        rd(2'd3, 5'd4, 2'd1, 5'd4, "R9");

        // R7: mode write, same-cycle access still uses old mode
        step(1, 1, 2'd1, 5'd3, 2'd0, 5'd0, 1, 2'd1, 5'd3, 128'h9999, "R7");
        rd(2'd1, 5'd3, 2'd1, 5'd2, "R7");

        // R8: extension bank separate from base bank
        wr(2'd1, 5'd3, 128'hE1E1_E1E1_E1E1_E1E1, "R8");
        wr(2'd2, 5'd9, {64'hC0C0_0000_0000_0001, 64'hC0C0_0000_0000_0002}, "R8");
        rd(2'd1, 5'd3, 2'd1, 5'd2, "R8");
        rd(2'd2, 5'd9, 2'd2, 5'd8, "R8");
        rd(2'd1, 5'd11, 2'd1, 5'd10, "R8");

        // R9: singles stay in base bank under extension mode
        wr(2'd0, 5'd3, 128'hABCD_EF01, "R9");
        rd(2'd0, 5'd3, 2'd1, 5'd3, "R9");
        step(1, 0, 2'd0, 5'd0, 2'd0, 5'd0, 0, 0, 0, '0, "R7");
        rd(2'd1, 5'd3, 2'd2, 5'd9, "R9");

        // R10: read during write returns old contents
        step(0, 0, 2'd1, 5'd20, 2'd0, 5'd21, 1, 2'd1, 5'd20, 128'h4242_4242_4242_4242, "R10");
        rd(2'd1, 5'd20, 2'd0, 5'd21, "R10");

        // mixed traffic
        for (int i = 0; i < 3000; i++) begin
            logic [1:0] p1, p2, pw;
            p1 = 2'($urandom_range(0, 3));
            p2 = 2'($urandom_range(0, 3));
            pw = 2'($urandom_range(0, 3));
            step(($urandom_range(0, 15) == 0), 1'($urandom), p1, 5'($urandom), p2, 5'($urandom),
                 1'($urandom), pw, 5'($urandom),
                 {$urandom, $urandom, $urandom, $urandom}, "");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule